// File: doc/BRIEF.md
# DSP Post-Modify Address Generator

This block forms the effective address of a load and keeps the address pointer that the load may update. It supports eight addressing modes. Two add an offset or a scaled index and leave the pointer alone. One uses an absolute constant and also writes it to the pointer. Five use the old pointer as the address and then advance it. The advancing modes are plain (by an immediate or by a modifier register), bit-reversed, and circular (by an immediate, or by a step packed into the modifier).

The effective address and the candidate next pointer are combinational functions of the current pointer and the request inputs. The pointer register takes the candidate value on the rising clock edge where the access strobe is high. The memory, the data formatting of the loaded bytes and the general register file all sit outside this block.

Top module: `dsp_agu`

## Requirements
- R1: While the active-low reset `rst_n` is low, the pointer `ptr_q` is 0, and it stays 0 until the first strobed access.
- R2: Mode 0 (offset): `eff_addr` = `ptr_q` + `imm`, and the pointer does not change.
- R3: Mode 1 (scaled index): `eff_addr` = (`ptr_q` << `shamt`) + `imm`, where `imm` is the absolute base, and the pointer does not change.
- R4: Mode 2 (absolute with write): `eff_addr` = `imm`, and a strobed access loads `imm` into the pointer.
- R5: Modes 3 and 4 (post-increment): `eff_addr` = `ptr_q`. The pointer then advances by `imm` (mode 3) or by `mod_reg` (mode 4), with two's-complement wraparound.
- R6: Mode 5 (bit-reversed): `eff_addr` = {`ptr_q`[31:16], the lower 16 pointer bits in reversed order}. The pointer advances by `mod_reg`, with no reversal.
- R7: Mode 6 (circular by immediate): the buffer length L is `mod_reg`[16:0] and the start is `circ_start`. The next pointer is `circ_start` + ((`ptr_q` − `circ_start` + `imm`) mod L). This holds for a signed step whose magnitude is below L and a pointer inside the buffer. `eff_addr` = `ptr_q`.
- R8: Mode 7 (circular by register): the step is `mod_reg`[23:17], read as a signed 7-bit value and shifted left by `size_log2` (the log2 of the access size in bytes). The wrap follows R7. `eff_addr` = `ptr_q`.
- R9: In modes 6 and 7, a length field of 0 disables wrapping, and the pointer advances by the step alone.
- R10: When `acc_valid` is low, the pointer holds its value in every mode, while `eff_addr` and `ptr_next` still follow the inputs.
- R11: `ptr_next` always shows the value that a strobed access in the current cycle would load into the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe; enables the pointer update |
| mode | input | 3 | Addressing mode select, 0 to 7 as listed in R2 to R8 |
| imm | input | 32 | Immediate: offset, absolute base/constant, or post-increment step |
| shamt | input | 2 | Index shift amount for mode 1 |
| mod_reg | input | 32 | Modifier: increment, or packed length [16:0] and step [23:17] |
| circ_start | input | 32 | Circular buffer start address |
| size_log2 | input | 2 | Log2 of the access size in bytes |
| eff_addr | output | 32 | Effective address of the access |
| ptr_next | output | 32 | Candidate next pointer value |
| ptr_q | output | 32 | Current pointer register |

## Verification
`eff_addr` and `ptr_next` are due in the same cycle as the stimulus, since no register lies on their path. `ptr_q` is due one rising edge after a strobed access. The bench changes inputs on the falling edge. It reads the combinational outputs 5 ns later, inside the low phase, and reads `ptr_q` 1 ns after the following rising edge. Long runs of bit-reversed and circular accesses carry pointer state from one vector to the next, so the wrap points and the reversal order are checked in sequence rather than one vector at a time.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [2:0] {
      AM_OFFSET   = 3'd0,
      AM_SCALED   = 3'd1,
      AM_ABSWR    = 3'd2,
      AM_PINC_IMM = 3'd3,
      AM_PINC_MOD = 3'd4,
      AM_BITREV   = 3'd5,
      AM_CIRC_IMM = 3'd6,
      AM_CIRC_MOD = 3'd7
   } agu_mode_e;
endpackage

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
   parameter int AW = 32,
   parameter int BB = 16
) (
   input  logic [AW-1:0] ptr,
   output logic [AW-1:0] addr
);
   if (BB < 1 || BB > AW) begin : g_bad
      $error("agu_bitrev: BB must lie in 1..AW");
   end

   logic [BB-1:0] rev;
   for (genvar i = 0; i < BB; i++) begin : g_rev
      assign rev[i] = ptr[BB-1-i];
   end

   if (BB == AW) begin : g_full
      assign addr = rev;
   end else begin : g_part
      assign addr = {ptr[AW-1:BB], rev};
   end
endmodule

// File: rtl/agu_circ_step.sv
module agu_circ_step #(
   parameter int AW = 32,
   parameter int LW = 17
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] start,
   input  logic [AW-1:0] step,
   input  logic [LW-1:0] len,
   output logic [AW-1:0] next
);
   if (LW >= AW) begin : g_bad
      $error("agu_circ_step: LW must be below AW");
   end

   logic [AW-1:0]          off;
   logic signed [AW+1:0]   sum;
   logic signed [AW+1:0]   len_s;
   logic signed [AW+1:0]   wrapped;

   assign off   = ptr - start;
   assign len_s = $signed({{(AW+2-LW){1'b0}}, len});
   assign sum   = $signed({2'b00, off}) + $signed({step[AW-1], step[AW-1], step});

   always_comb begin
      if (sum >= len_s)
         wrapped = sum - len_s;
      else if (sum < 0)
         wrapped = sum + len_s;
      else
         wrapped = sum;
      // R7
      if (len != '0 && sum > -len_s && sum < (len_s <<< 1)) begin
         circ_in_window_chk: assert (wrapped >= 0 && wrapped < len_s);
      end
   end

   assign next = (len == '0) ? ptr + step : start + wrapped[AW-1:0];
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
   import agu_pkg::*;
#(
   parameter int AW  = 32,
   parameter int LW  = 17,
   parameter int IW  = 7,
   parameter int BB  = 16,
   parameter int SW  = 2,
   parameter int SHW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_valid,
   input  logic [2:0]    mode,
   input  logic [31:0]   imm,
   input  logic [SHW-1:0] shamt,
   input  logic [31:0]   mod_reg,
   input  logic [31:0]   circ_start,
   input  logic [SW-1:0] size_log2,
   output logic [31:0]   eff_addr,
   output logic [31:0]   ptr_next,
   output logic [31:0]   ptr_q
);
   localparam int INC_LSB = LW;
   localparam int INC_MSB = LW + IW - 1;

   if (AW != 32) begin : g_bad_aw
      $error("dsp_agu: ports are 32 bits wide, AW must be 32");
   end
   if (INC_MSB >= AW) begin : g_bad_fields
      $error("dsp_agu: length and step fields exceed the modifier width");
   end

   agu_mode_e     md;
   logic [AW-1:0] brev_addr;
   logic [AW-1:0] circ_next;
   logic [AW-1:0] circ_step;
   logic [AW-1:0] reg_step;
   logic [IW-1:0] inc_fld;

   assign md      = agu_mode_e'(mode);
   assign inc_fld = mod_reg[INC_MSB:INC_LSB];
   assign reg_step = {{(AW-IW){inc_fld[IW-1]}}, inc_fld} << size_log2;
   assign circ_step = (md == AM_CIRC_MOD) ? reg_step : imm;

   agu_bitrev #(.AW(AW), .BB(BB)) u_brev (
      .ptr  (ptr_q),
      .addr (brev_addr)
   );

   agu_circ_step #(.AW(AW), .LW(LW)) u_circ (
      .ptr   (ptr_q),
      .start (circ_start),
      .step  (circ_step),
      .len   (mod_reg[LW-1:0]),
      .next  (circ_next)
   );

   always_comb begin
      eff_addr = ptr_q;
      ptr_next = ptr_q;
      unique case (md)
         AM_OFFSET:   eff_addr = ptr_q + imm;
         AM_SCALED:   eff_addr = (ptr_q << shamt) + imm;
         AM_ABSWR: begin
            eff_addr = imm;
            ptr_next = imm;
         end
         AM_PINC_IMM: ptr_next = ptr_q + imm;
         AM_PINC_MOD: ptr_next = ptr_q + mod_reg;
         AM_BITREV: begin
            eff_addr = brev_addr;
            ptr_next = ptr_q + mod_reg;
         end
         AM_CIRC_IMM,
         AM_CIRC_MOD: ptr_next = circ_next;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (acc_valid)
         ptr_q <= ptr_next;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> ptr_q == '0);

   // R2
   offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && (md == AM_OFFSET || md == AM_SCALED) |=> $stable(ptr_q));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(ptr_q));

   // R4
   abs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && md == AM_ABSWR |=> ptr_q == $past(imm));

   // R5
   post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md == AM_PINC_IMM || md == AM_PINC_MOD || md == AM_CIRC_IMM || md == AM_CIRC_MOD)
      |-> eff_addr == ptr_q);

   // R11
   next_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> ptr_q == $past(ptr_next));

   if (BB < AW) begin : g_brev_chk
      // R6
      brev_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
         md == AM_BITREV |-> eff_addr[AW-1:BB] == ptr_q[AW-1:BB]);
   end
endmodule

// File: tb/dsp_agu_tb_top.sv
module dsp_agu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [31:0] imm = '0;
   logic [1:0]  shamt = '0;
   logic [31:0] mod_reg = '0;
   logic [31:0] circ_start = '0;
   logic [1:0]  size_log2 = '0;
   logic [31:0] eff_addr;
   logic [31:0] ptr_next;
   logic [31:0] ptr_q;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dsp_agu dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .mode(mode), .imm(imm),
      .shamt(shamt), .mod_reg(mod_reg), .circ_start(circ_start), .size_log2(size_log2),
      .eff_addr(eff_addr), .ptr_next(ptr_next), .ptr_q(ptr_q)
   );

   typedef struct packed {
      logic        v;
      logic [2:0]  md;
      logic [31:0] im;
      logic [31:0] mr;
      logic [1:0]  sz;
      logic [1:0]  sh;
      logic [31:0] ea;
      logic [31:0] np;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 3'd2, 32'h0000_1000, 32'h0,        2'd0, 2'd0, 32'h0000_1000, 32'h0000_1000, 8'd4},  // R4
      '{1'b1, 3'd0, 32'h0000_0024, 32'h0,        2'd0, 2'd0, 32'h0000_1024, 32'h0000_1000, 8'd2},  // R2
      '{1'b1, 3'd1, 32'h8000_0000, 32'h0,        2'd0, 2'd2, 32'h8000_4000, 32'h0000_1000, 8'd3},  // R3
      '{1'b1, 3'd3, 32'h0000_0004, 32'h0,        2'd0, 2'd0, 32'h0000_1000, 32'h0000_1004, 8'd5},  // R5
      '{1'b1, 3'd3, 32'hFFFF_FFF8, 32'h0,        2'd0, 2'd0, 32'h0000_1004, 32'h0000_0FFC, 8'd5},  // R5
      '{1'b1, 3'd4, 32'h0,         32'h10,       2'd0, 2'd0, 32'h0000_0FFC, 32'h0000_100C, 8'd5},  // R5
      '{1'b0, 3'd3, 32'h0000_0004, 32'h0,        2'd0, 2'd0, 32'h0000_100C, 32'h0000_100C, 8'd10}, // R10
      '{1'b1, 3'd2, 32'h0003_0000, 32'h0,        2'd0, 2'd0, 32'h0003_0000, 32'h0003_0000, 8'd4},  // R4
      '{1'b1, 3'd5, 32'h0,         32'h1000,     2'd0, 2'd0, 32'h0003_0000, 32'h0003_1000, 8'd6},  // R6
      '{1'b1, 3'd5, 32'h0,         32'h1000,     2'd0, 2'd0, 32'h0003_0008, 32'h0003_2000, 8'd6},  // R6
      '{1'b1, 3'd5, 32'h0,         32'h1000,     2'd0, 2'd0, 32'h0003_0004, 32'h0003_3000, 8'd6},  // R6
      '{1'b1, 3'd5, 32'h0,         32'h1000,     2'd0, 2'd0, 32'h0003_000C, 32'h0003_4000, 8'd6},  // R6
      '{1'b1, 3'd2, 32'h0000_2000, 32'h0,        2'd0, 2'd0, 32'h0000_2000, 32'h0000_2000, 8'd4},  // R4
      '{1'b1, 3'd6, 32'h0000_0002, 32'h6,        2'd0, 2'd0, 32'h0000_2000, 32'h0000_2002, 8'd7},  // R7
      '{1'b1, 3'd6, 32'h0000_0002, 32'h6,        2'd0, 2'd0, 32'h0000_2002, 32'h0000_2004, 8'd7},  // R7
      '{1'b1, 3'd6, 32'h0000_0002, 32'h6,        2'd0, 2'd0, 32'h0000_2004, 32'h0000_2000, 8'd7},  // R7 wrap
      '{1'b1, 3'd6, 32'hFFFF_FFFE, 32'h6,        2'd0, 2'd0, 32'h0000_2000, 32'h0000_2004, 8'd7},  // R7 backward
      '{1'b1, 3'd2, 32'h0000_2000, 32'h0,        2'd0, 2'd0, 32'h0000_2000, 32'h0000_2000, 8'd4},  // R4
      '{1'b1, 3'd7, 32'h0,         32'h0004_0008, 2'd1, 2'd0, 32'h0000_2000, 32'h0000_2004, 8'd8}, // R8
      '{1'b1, 3'd7, 32'h0,         32'h0004_0008, 2'd1, 2'd0, 32'h0000_2004, 32'h0000_2000, 8'd8}, // R8 wrap
      '{1'b1, 3'd7, 32'h0,         32'h0002_0008, 2'd2, 2'd0, 32'h0000_2000, 32'h0000_2004, 8'd8}, // R8
      '{1'b1, 3'd6, 32'h0000_0010, 32'h0,        2'd0, 2'd0, 32'h0000_2004, 32'h0000_2014, 8'd9},  // R9
      '{1'b1, 3'd7, 32'h0,         32'h00FE_0000, 2'd0, 2'd0, 32'h0000_2014, 32'h0000_2013, 8'd9}, // R9 signed step
      '{1'b1, 3'd5, 32'h0,         32'h1,        2'd0, 2'd0, 32'h0000_C804, 32'h0000_2014, 8'd6}   // R6
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   initial begin
      #(20 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      circ_start = 32'h0000_2000;
      repeat (3) @(negedge clk);
      check("R1", "ptr_q in reset", ptr_q, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "ptr_q after reset", ptr_q, 32'h0);

      for (int k = 0; k < NV; k++) begin
         string rq;
         rq = $sformatf("R%0d", VECS[k].rq);
         @(negedge clk);
         acc_valid = VECS[k].v;
         mode      = VECS[k].md;
         imm       = VECS[k].im;
         mod_reg   = VECS[k].mr;
         size_log2 = VECS[k].sz;
         shamt     = VECS[k].sh;
         #5;
         check(rq, $sformatf("eff_addr vec %0d", k), eff_addr, VECS[k].ea);
         if (VECS[k].v)
            check("R11", $sformatf("ptr_next vec %0d", k), ptr_next, VECS[k].np);
         @(posedge clk); #1;
         check(rq, $sformatf("ptr_q vec %0d", k), ptr_q, VECS[k].np);
      end

      // R10: absolute-write mode with strobe low leaves the pointer alone
      @(negedge clk);
      acc_valid = 1'b0; mode = 3'd2; imm = 32'hDEAD_0000;
      #5;
      check("R10", "eff_addr idle abs", eff_addr, 32'hDEAD_0000);
      check("R10", "ptr_next idle abs", ptr_next, 32'hDEAD_0000);
      @(posedge clk); #1;
      check("R10", "ptr_q idle abs", ptr_q, 32'h0000_2014);

      // R1: reset in mid-run clears the pointer
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R1", "ptr_q mid-run reset", ptr_q, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      mode = 3'd0; imm = 32'h0000_0040;
      #5;
      check("R2", "eff_addr after reset", eff_addr, 32'h0000_0040);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule